// File: doc/BRIEF.md
# Staged-Segment Binary CAM Search Array

This block is a binary content addressable memory of 128 words, each 136 bits wide. Software-independent logic writes words through a simple write port and presents search keys on a search port. The block then reports every stored word that equals the key, whether any did, and the index of the lowest such word. Each word is divided into a short prefix segment and four wider suffix segments. Every valid entry compares its prefix on each search. The suffix comparators of an entry are enabled only when that entry's prefix agrees, so most suffix comparisons are gated off. A per-search count reports how many entries had their suffix segments enabled.

Results are qualified by a replica timing path. A search start clears a completion latch. A replica delay of a configurable number of cycles sets it, and this produces a one-cycle qualifier. Match information is registered only under that qualifier. In every other cycle the result outputs read as zero. A write issued while a search is in flight is parked and committed when that search finishes, so a search always sees one consistent array.

Top module: `staged_cam`

## Requirements
- R1: A write with `wr_en` high while no search is in flight stores `wr_data` at `wr_addr` together with the valid flag `wr_valid`. A search started on any later edge sees that word.
- R2: The key prefix is bits 135:128 and suffix segment j is bits 32j+31:32j. An entry matches only when it is valid and all 136 bits equal the key. A difference in any single bit, whether prefix or suffix, gives a miss.
- R3: `sfx_cnt` equals the number of valid entries whose prefix equals the key prefix, whatever their suffix contents.
- R4: Bit i of `match_vec` is 1 exactly when entry i is valid and fully equal to the key.
- R5: When several entries match, `hit_addr` is the lowest matching index and `hit` is 1. When none match, `hit` is 0 and `hit_addr` is 0.
- R6: A search is accepted on a rising edge where `srch_req` is high and no search is in flight. Its result appears with `res_valid` high for exactly one cycle, `REPLICA_DLY` edges after acceptance.
- R7: In every cycle where `res_valid` is low, `match_vec`, `hit`, `hit_addr` and `sfx_cnt` are all zero.
- R8: A `srch_req` raised while a search is in flight is ignored and produces no result.
- R9: Writes issued while a search is in flight are invisible to that search. Only the most recent of them is kept, and it is committed as the search completes.
- R10: After reset, no result is pending and every entry is invalid, so a search returns no match and a zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 7 | Entry index to write |
| wr_data | input | 136 | Word to store |
| wr_valid | input | 1 | Valid flag stored with the word |
| srch_req | input | 1 | Search request |
| srch_key | input | 136 | Search key |
| res_valid | output | 1 | One-cycle result strobe |
| match_vec | output | 128 | Per-entry match flags |
| hit | output | 1 | At least one entry matched |
| hit_addr | output | 7 | Lowest matching index, zero on a miss |
| sfx_cnt | output | 8 | Entries whose suffix segments were enabled |

## Verification
The hardest situation to reach from the ports is a write that lands inside a search window: two writes to the same entry during one search, the second one in the qualifier cycle itself. The stimulus raises `wr_en` on both in-flight cycles of a two-cycle replica delay, with different data each time. In the same window it also raises a stray search request. Follow-up searches then show that only the second write took effect, and the scoreboard shows that the stray request produced no result.

// File: rtl/scam_pkg.sv
package scam_pkg;
  localparam int unsigned DEF_ENTRIES = 128;
  localparam int unsigned DEF_PFX_W   = 8;
  localparam int unsigned DEF_SEG_W   = 32;
  localparam int unsigned DEF_NUM_SEG = 4;
  localparam int unsigned DEF_DLY     = 1;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_EVAL = 1'b1
  } srch_phase_e;
endpackage

// File: rtl/scam_entry.sv
module scam_entry #(
  parameter int unsigned PFX_W   = scam_pkg::DEF_PFX_W,
  parameter int unsigned SEG_W   = scam_pkg::DEF_SEG_W,
  parameter int unsigned NUM_SEG = scam_pkg::DEF_NUM_SEG,
  localparam int unsigned WORD_W = PFX_W + SEG_W * NUM_SEG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              wvalid,
  input  logic [WORD_W-1:0] key,
  output logic              pfx_hit,
  output logic              word_hit
);
  logic [WORD_W-1:0] word_q;
  logic              vld_q;
  logic              vld_n;
  logic [NUM_SEG-1:0] seg_ok;

  // storage: data has no reset, valid flag does
  always_ff @(posedge clk) begin
    if (we) word_q <= wdata;
  end

  always_comb begin
    vld_n = vld_q;
    if (we) vld_n = wvalid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_n;
  end

  // first stage: prefix compare, always active for valid entries
  assign pfx_hit = vld_q && (word_q[WORD_W-1 -: PFX_W] == key[WORD_W-1 -: PFX_W]);

  // second stage: suffix comparators enabled only by a prefix hit
  for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
    assign seg_ok[j] = pfx_hit && (word_q[j*SEG_W +: SEG_W] == key[j*SEG_W +: SEG_W]);
  end

  assign word_hit = &seg_ok;
endmodule

// File: rtl/scam_replica.sv
module scam_replica #(
  parameter int unsigned DLY = scam_pkg::DEF_DLY,
  localparam int unsigned AGE_W = (DLY > 1) ? $clog2(DLY) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic qual
);
  import scam_pkg::*;

  srch_phase_e ph_q, ph_n;
  logic [AGE_W-1:0] age_q, age_n;
  logic done_q, done_n;
  logic age_end;

  assign age_end = (age_q == AGE_W'(DLY - 1));
  assign busy    = (ph_q == PH_EVAL);
  // qualifier: replica finished, completion latch not yet set
  assign qual    = busy && age_end && !done_q;

  always_comb begin
    ph_n   = ph_q;
    age_n  = age_q;
    done_n = done_q;
    if (start) begin
      ph_n   = PH_EVAL;
      age_n  = '0;
      done_n = 1'b0;          // global enable clears the latch
    end else if (busy) begin
      if (age_end) begin
        ph_n   = PH_IDLE;
        done_n = 1'b1;        // replica completion sets it
      end else begin
        age_n  = age_q + AGE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      age_q  <= '0;
      done_q <= 1'b1;
    end else begin
      ph_q   <= ph_n;
      age_q  <= age_n;
      done_q <= done_n;
    end
  end
endmodule

// File: rtl/scam_resolve.sv
module scam_resolve #(
  parameter int unsigned N = scam_pkg::DEF_ENTRIES,
  localparam int unsigned ADDR_W = $clog2(N),
  localparam int unsigned CNT_W  = $clog2(N + 1)
) (
  input  logic [N-1:0]      hits,
  input  logic [N-1:0]      enabled,
  output logic              any_hit,
  output logic [ADDR_W-1:0] low_addr,
  output logic [CNT_W-1:0]  en_cnt
);
  always_comb begin
    low_addr = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) low_addr = ADDR_W'(i);
    end
  end

  always_comb begin
    en_cnt = '0;
    for (int i = 0; i < N; i++) begin
      en_cnt = en_cnt + CNT_W'(enabled[i]);
    end
  end

  assign any_hit = |hits;
endmodule

// File: rtl/staged_cam.sv
module staged_cam #(
  parameter int unsigned NUM_ENTRIES = scam_pkg::DEF_ENTRIES,
  parameter int unsigned PFX_W       = scam_pkg::DEF_PFX_W,
  parameter int unsigned SEG_W       = scam_pkg::DEF_SEG_W,
  parameter int unsigned NUM_SEG     = scam_pkg::DEF_NUM_SEG,
  parameter int unsigned REPLICA_DLY = scam_pkg::DEF_DLY,
  localparam int unsigned WORD_W = PFX_W + SEG_W * NUM_SEG,
  localparam int unsigned ADDR_W = $clog2(NUM_ENTRIES),
  localparam int unsigned CNT_W  = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [WORD_W-1:0]      wr_data,
  input  logic                   wr_valid,
  input  logic                   srch_req,
  input  logic [WORD_W-1:0]      srch_key,
  output logic                   res_valid,
  output logic [NUM_ENTRIES-1:0] match_vec,
  output logic                   hit,
  output logic [ADDR_W-1:0]      hit_addr,
  output logic [CNT_W-1:0]       sfx_cnt
);
  logic busy, qual, accept;
  logic [WORD_W-1:0] key_q;

  // parked write
  logic              pend_v_q, pend_v_n;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [WORD_W-1:0] pend_data_q;
  logic              pend_vld_q;
  logic              pend_load;

  // array write port
  logic              arr_we;
  logic [ADDR_W-1:0] arr_addr;
  logic [WORD_W-1:0] arr_data;
  logic              arr_vld;

  logic [NUM_ENTRIES-1:0] pfx_hits, word_hits;
  logic              any_hit;
  logic [ADDR_W-1:0] low_addr;
  logic [CNT_W-1:0]  en_cnt;

  assign accept = srch_req && !busy;

  scam_replica #(.DLY(REPLICA_DLY)) u_replica (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .busy  (busy),
    .qual  (qual)
  );

  always_ff @(posedge clk) begin
    if (accept) key_q <= srch_key;
  end

  // write steering: direct when idle, parked while busy, commit at qual
  assign pend_load = wr_en && busy && !qual;

  always_comb begin
    arr_we   = 1'b0;
    arr_addr = wr_addr;
    arr_data = wr_data;
    arr_vld  = wr_valid;
    if (!busy) begin
      arr_we = wr_en;
    end else if (qual) begin
      arr_we = wr_en || pend_v_q;
      if (!wr_en) begin
        arr_addr = pend_addr_q;
        arr_data = pend_data_q;
        arr_vld  = pend_vld_q;
      end
    end
  end

  always_comb begin
    pend_v_n = pend_v_q;
    if (qual)           pend_v_n = 1'b0;
    else if (pend_load) pend_v_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_v_q <= 1'b0;
    else        pend_v_q <= pend_v_n;
  end

  always_ff @(posedge clk) begin
    if (pend_load) begin
      pend_addr_q <= wr_addr;
      pend_data_q <= wr_data;
      pend_vld_q  <= wr_valid;
    end
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    scam_entry #(
      .PFX_W   (PFX_W),
      .SEG_W   (SEG_W),
      .NUM_SEG (NUM_SEG)
    ) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (arr_we && (arr_addr == ADDR_W'(i))),
      .wdata    (arr_data),
      .wvalid   (arr_vld),
      .key      (key_q),
      .pfx_hit  (pfx_hits[i]),
      .word_hit (word_hits[i])
    );
  end

  scam_resolve #(.N(NUM_ENTRIES)) u_resolve (
    .hits     (word_hits),
    .enabled  (pfx_hits),
    .any_hit  (any_hit),
    .low_addr (low_addr),
    .en_cnt   (en_cnt)
  );

  // result registers, gated by the replica qualifier
  logic                   rv_n, hit_n;
  logic [NUM_ENTRIES-1:0] vec_n;
  logic [ADDR_W-1:0]      addr_n;
  logic [CNT_W-1:0]       cnt_n;

  always_comb begin
    rv_n   = qual;
    vec_n  = '0;
    hit_n  = 1'b0;
    addr_n = '0;
    cnt_n  = '0;
    if (qual) begin
      vec_n  = word_hits;
      hit_n  = any_hit;
      addr_n = low_addr;
      cnt_n  = en_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      match_vec <= '0;
      hit       <= 1'b0;
      hit_addr  <= '0;
      sfx_cnt   <= '0;
    end else begin
      res_valid <= rv_n;
      match_vec <= vec_n;
      hit       <= hit_n;
      hit_addr  <= addr_n;
      sfx_cnt   <= cnt_n;
    end
  end
endmodule

// File: rtl/scam_chk.sv
module scam_chk #(
  parameter int unsigned N = scam_pkg::DEF_ENTRIES,
  localparam int unsigned ADDR_W = $clog2(N),
  localparam int unsigned CNT_W  = $clog2(N + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic [N-1:0]      match_vec,
  input logic              hit,
  input logic [ADDR_W-1:0] hit_addr,
  input logic [CNT_W-1:0]  sfx_cnt
);
  logic [N-1:0] below_mask;
  assign below_mask = (N'(1) << hit_addr) - N'(1);

  // R7
  quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (match_vec == '0 && !hit && hit_addr == '0 && sfx_cnt == '0));

  // R5
  hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (hit == (match_vec != '0)));

  // R5
  lowest_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && hit) |-> (match_vec[hit_addr] && ((match_vec & below_mask) == '0)));

  // R5
  miss_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !hit) |-> (hit_addr == '0));

  // R3
  gated_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones(match_vec) <= int'(sfx_cnt)));

  // R6
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

bind staged_cam scam_chk #(.N(NUM_ENTRIES)) u_scam_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_valid (res_valid),
  .match_vec (match_vec),
  .hit       (hit),
  .hit_addr  (hit_addr),
  .sfx_cnt   (sfx_cnt)
);

// File: tb/staged_cam_test.sv
module staged_cam_test;
  localparam int N   = 128;
  localparam int W   = 136;
  localparam int AW  = 7;
  localparam int CW  = 8;
  localparam int DLY = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_valid, srch_req;
  logic [AW-1:0] wr_addr;
  logic [W-1:0]  wr_data, srch_key;
  logic res_valid, hit;
  logic [N-1:0]  match_vec;
  logic [AW-1:0] hit_addr;
  logic [CW-1:0] sfx_cnt;

  always #10 clk = ~clk;   // 50 MHz

  staged_cam #(.REPLICA_DLY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_valid(wr_valid), .srch_req(srch_req),
    .srch_key(srch_key), .res_valid(res_valid), .match_vec(match_vec),
    .hit(hit), .hit_addr(hit_addr), .sfx_cnt(sfx_cnt)
  );

  typedef struct packed {
    logic [N-1:0]  vec;
    logic          hit;
    logic [AW-1:0] addr;
    logic [CW-1:0] cnt;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  logic [W-1:0] ref_mem [N];
  logic         ref_vld [N];
  int checks = 0;
  int errors = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  function automatic logic [W-1:0] word_of(int i);
    logic [7:0]  p;
    logic [31:0] s3, s2, s1, s0;
    p  = 8'(i % 8);
    s3 = 32'(i) * 32'h9E37_79B1;
    s2 = 32'hC0DE_0000 | 32'(i);
    s1 = ~32'(i * 3);
    s0 = 32'hA500_0000 + 32'(i);
    return {p, s3, s2, s1, s0};
  endfunction

  function automatic exp_t model(logic [W-1:0] k);
    exp_t e;
    e = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ref_vld[i] && ref_mem[i][W-1 -: 8] == k[W-1 -: 8]) begin
        e.cnt = e.cnt + 1'b1;
        if (ref_mem[i] == k) begin
          e.vec[i] = 1'b1;
          e.hit    = 1'b1;
          e.addr   = AW'(i);
        end
      end
    end
    return e;
  endfunction

  task automatic check(bit ok, string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // write while idle (R1)
  task automatic wr(int a, logic [W-1:0] d, logic v);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
    ref_mem[a] = d;
    ref_vld[a] = v;
  endtask

  // driver: push expected, issue the search, wait for its result slot
  task automatic srch(logic [W-1:0] k, string tag);
    exp_q.push_back(model(k));
    tag_q.push_back(tag);
    srch_req = 1'b1; srch_key = k;
    @(negedge clk);
    srch_req = 1'b0;
    repeat (DLY) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (running && rst_n) begin
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected result", match_vec, '0);
        end else begin
          exp_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(match_vec == e.vec, t, "match_vec", match_vec, e.vec);
          check(hit == e.hit, t, "hit", N'(hit), N'(e.hit));
          check(hit_addr == e.addr, t, "hit_addr", N'(hit_addr), N'(e.addr));
          check(sfx_cnt == e.cnt, t, "sfx_cnt", N'(sfx_cnt), N'(e.cnt));
        end
      end else begin
        // R7 outputs quiet outside the result cycle
        check(match_vec == '0 && !hit && hit_addr == '0 && sfx_cnt == '0,
              "R7", "idle outputs", match_vec, '0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [W-1:0] k;
    rst_n = 1'b0; wr_en = 1'b0; srch_req = 1'b0;
    wr_addr = '0; wr_data = '0; wr_valid = 1'b0; srch_key = '0;
    for (int i = 0; i < N; i++) begin ref_mem[i] = '0; ref_vld[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state at the ports
    check(!res_valid && match_vec == '0 && !hit && sfx_cnt == '0, "R10", "reset outputs",
          match_vec, '0);
    running = 1'b1;
    srch('0, "R10 empty array");
    srch(word_of(0), "R10 no valid entries");

    // R1 fill, every sixteenth entry written invalid
    for (int i = 0; i < N; i++) wr(i, word_of(i), (i % 16) != 15);

    srch(word_of(5), "R4 single hit");
    srch(word_of(0), "R5 hit at index 0");
    srch(word_of(127), "R1 invalid entry 127");
    srch(word_of(126), "R4 hit at index 126");
    k = word_of(13); k[W-1 -: 8] = 8'hFF;
    srch(k, "R3 no prefix agrees");
    k = word_of(13); k[0] = ~k[0];
    srch(k, "R2 lsb differs");
    k = word_of(13); k[W-1] = ~k[W-1];
    srch(k, "R2 prefix msb differs");
    k = word_of(13); k[70] = ~k[70];
    srch(k, "R3 prefix hit suffix miss");

    // R5 duplicates: lowest wins
    wr(90, word_of(20), 1'b1);
    wr(40, word_of(20), 1'b1);
    srch(word_of(20), "R5 lowest of three");
    wr(20, word_of(20), 1'b0);
    srch(word_of(20), "R5 lowest after invalidate");

    // R9 + R8: two writes and a stray request inside one search window
    exp_q.push_back(model(word_of(3)));
    tag_q.push_back("R9 search unaffected by parked writes");
    srch_req = 1'b1; srch_key = word_of(3);
    @(negedge clk);                      // busy, age 0
    srch_req = 1'b1; srch_key = word_of(9);   // ignored, R8
    wr_en = 1'b1; wr_addr = AW'(3); wr_data = word_of(200); wr_valid = 1'b1;
    @(negedge clk);                      // qualifier cycle
    srch_req = 1'b0;
    wr_en = 1'b1; wr_addr = AW'(3); wr_data = word_of(300); wr_valid = 1'b1;
    @(negedge clk);                      // result cycle
    wr_en = 1'b0;
    ref_mem[3] = word_of(300); ref_vld[3] = 1'b1;
    srch(word_of(300), "R9 latest parked write committed");
    srch(word_of(200), "R9 earlier parked write dropped");
    srch(word_of(3), "R9 old word gone");
    srch(word_of(9), "R8 stray key now searched");

    // R6 back-to-back: request held high, accepted only when idle
    exp_q.push_back(model(word_of(44)));
    tag_q.push_back("R6 held request first");
    srch_req = 1'b1; srch_key = word_of(44);
    @(negedge clk);
    srch_key = word_of(45);
    repeat (DLY) @(negedge clk);
    exp_q.push_back(model(word_of(45)));
    tag_q.push_back("R6 held request second");
    @(negedge clk);
    srch_req = 1'b0;
    repeat (DLY + 2) @(negedge clk);

    running = 1'b0;
    check(exp_q.size() == 0, "R6", "results outstanding", N'(exp_q.size()), '0);
    finish_run();
  end
endmodule